// File: doc/BRIEF.md
# NOR Flash Erase and Program Sequencer

This block drives a parallel NOR flash through its command register to erase one block or to program one word. A host gives an operation select, an address, a data word and a poll limit, and pulses a start strobe. The sequencer then runs the whole exchange on a synchronous flash port. It clears the device status, issues the command pair, and polls the status register until the device reports ready or the poll budget runs out. It then returns the device to read-array mode and checks the result of the operation.

The status byte is reduced to one result code. An error bit that does not match the operation is an unknown hardware fault. A matching error is ranked as low voltage first, then protection, then a plain erase or program failure. After an erase, the block is read word by word from its base and compared with all-ones. After a successful program, the word is read back and compared with the data that was written. When the sequence ends, the block raises a one-cycle completion pulse. The result stays on its output until the host starts the next request.

Top module: `nflash_seq`

## Requirements
- R1: A start strobe seen while idle is accepted. In the next cycle, busy is high and the block writes the clear-status command 0x50 to the request address.
- R2: An erase (req_erase=1) writes 0x20 and then 0xD0 to the request address. A program (req_erase=0) writes 0x40 and then the data word to the request address.
- R3: After the command pair, the block reads status at the request address until bit 7 is set. If the poll_limit-th read (a limit of 0 acts as 1) still lacks bit 7, the result is TIMEOUT and no more status reads are made.
- R4: A ready status with bits 6..1 all clear gives OK. If any of those bits is set but the operation bit (bit 5 for erase, bit 4 for program) is clear, the result is HW_ERROR. Otherwise bit 3 gives LOW_VOLTAGE, else bit 1 gives PROTECTED, else the result is ERASE_FAIL or PROGRAM_FAIL.
- R5: Once polling ends, by ready or by timeout, the block writes 0xFF to the request address before any array read.
- R6: After every erase, including a failed or timed-out one, the block reads the block's words in ascending order from the aligned base and compares each with all-ones. The first mismatch stops the sweep and gives VERIFY_FAIL, but only when the result was still OK.
- R7: After a program whose result is OK, the block reads the target word once. A value other than the written data gives VERIFY_FAIL. A program with any other result makes no array read.
- R8: Result codes are OK=0, TIMEOUT=1, HW_ERROR=2, LOW_VOLTAGE=3, PROTECTED=4, ERASE_FAIL=5, PROGRAM_FAIL=6, VERIFY_FAIL=7. The result is 0 after reset and does not change between the end of one operation and the next accepted start.
- R9: Done is high for exactly one cycle per operation, and busy is low in the cycle after it. Both are low after reset.
- R10: A start strobe while busy is ignored. The running operation finishes unchanged and produces one done pulse.
- R11: Flash write and read strobes are never high in the same cycle. Read data is taken from the flash in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe, accepted only while idle |
| req_erase | input | 1 | 1 = erase block, 0 = program word |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| poll_limit | input | TW | Maximum number of status reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code (R8) |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data / command |
| fl_rdata | input | DW | Flash read data, valid the cycle after fl_re |

## Verification
The bench counts status reads at the exact poll-limit boundary, with the device ready on the last allowed read and again one read late, and with a limit of zero. An off-by-one timer would turn an OK into a TIMEOUT, or the reverse. Status words with several error bits set check the decode order. A decoder with the wrong order would report PROTECTED where LOW_VOLTAGE is due, or would miss the unknown-fault case when the operation bit is absent. A block with one stuck word checks that the sweep stops right after the mismatch and that an earlier device error is not overwritten by VERIFY_FAIL. A start strobe in the middle of an operation checks that a design which re-captured the request would issue extra bus writes or touch another block.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_TIMEOUT = 3'd1,
    RES_HWERR   = 3'd2,
    RES_LOWV    = 3'd3,
    RES_PROT    = 3'd4,
    RES_ERASE   = 3'd5,
    RES_PROG    = 3'd6,
    RES_VERIFY  = 3'd7
  } nfs_res_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CLR,
    S_CMD,
    S_ARG,
    S_PRD,
    S_PWT,
    S_ARR,
    S_VRD,
    S_VWT,
    S_DONE
  } nfs_state_e;

  localparam logic [7:0] CMD_CLR_STAT = 8'h50;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CONFIRM  = 8'hD0;
  localparam logic [7:0] CMD_PROGRAM  = 8'h40;
  localparam logic [7:0] CMD_ARRAY    = 8'hFF;

  localparam int ST_READY   = 7;
  localparam int ST_ERASE   = 5;
  localparam int ST_PROGRAM = 4;
  localparam int ST_LOWV    = 3;
  localparam int ST_LOCKED  = 1;

endpackage

// File: rtl/nfs_status_decode.sv
module nfs_status_decode
  import nfs_pkg::*;
(
  input  logic [7:0] status,
  input  logic       is_erase,
  output nfs_res_e   res
);

  logic any_err;
  logic op_bit;

  assign any_err = |status[6:1];
  assign op_bit  = is_erase ? status[ST_ERASE] : status[ST_PROGRAM];

  always_comb begin
    if (!any_err) begin
      res = RES_OK;
    end else if (!op_bit) begin
      res = RES_HWERR;
    end else if (status[ST_LOWV]) begin
      res = RES_LOWV;
    end else if (status[ST_LOCKED]) begin
      res = RES_PROT;
    end else begin
      res = is_erase ? RES_ERASE : RES_PROG;
    end
  end

endmodule

// File: rtl/nfs_poll_timer.sv
module nfs_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [TW-1:0] limit,
  output logic          last
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;
  logic [TW:0]   reads_after;

  assign reads_after = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
  assign last        = reads_after >= {1'b0, limit};

  assign cnt_en = clr | step;
  assign cnt_d  = clr ? '0 : cnt_q + {{(TW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/nfs_sweep_ctr.sv
module nfs_sweep_ctr #(
  parameter int AW       = 8,
  parameter int BLK_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [AW-BLK_LOG2-1:0] blk_q;
  logic [BLK_LOG2-1:0]    off_q;
  logic [BLK_LOG2-1:0]    off_d;
  logic                   off_en;

  assign off_en = load | inc;
  assign off_d  = load ? '0 : off_q + {{(BLK_LOG2-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (load) begin
      blk_q <= base[AW-1:BLK_LOG2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (off_en) begin
      off_q <= off_d;
    end
  end

  assign addr = {blk_q, off_q};
  assign last = &off_q;

endmodule

// File: rtl/nflash_seq.sv
module nflash_seq
  import nfs_pkg::*;
#(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int BLK_LOG2 = 4,
  parameter int TW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic          req_erase,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [TW-1:0] poll_limit,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic          fl_we,
  output logic          fl_re,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  input  logic [DW-1:0] fl_rdata
);

  localparam logic [DW-1:0] BLANK = '1;

  nfs_state_e    state_q, state_d;
  nfs_res_e      res_q, res_d;
  nfs_res_e      dec_res;
  logic          erase_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [TW-1:0] limit_q;

  logic          start_acc;
  logic          ready;
  logic          tmr_last;
  logic          tmr_step;
  logic          sw_inc;
  logic          sw_last;
  logic [AW-1:0] sw_addr;
  logic [DW-1:0] expect_w;
  logic          match;

  assign start_acc = req_start && (state_q == S_IDLE);
  assign ready     = fl_rdata[ST_READY];
  assign expect_w  = erase_q ? BLANK : data_q;
  assign match     = (fl_rdata == expect_w);
  assign tmr_step  = (state_q == S_PWT) && !ready && !tmr_last;
  assign sw_inc    = (state_q == S_VWT) && match && erase_q && !sw_last;

  nfs_status_decode u_dec (
    .status   (fl_rdata[7:0]),
    .is_erase (erase_q),
    .res      (dec_res)
  );

  nfs_poll_timer #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_acc),
    .step  (tmr_step),
    .limit (limit_q),
    .last  (tmr_last)
  );

  nfs_sweep_ctr #(.AW(AW), .BLK_LOG2(BLK_LOG2)) u_sweep (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_acc),
    .inc   (sw_inc),
    .base  (req_addr),
    .addr  (sw_addr),
    .last  (sw_last)
  );

  // next state and result
  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_acc) begin
          state_d = S_CLR;
          res_d   = RES_OK;
        end
      end
      S_CLR:  state_d = S_CMD;
      S_CMD:  state_d = S_ARG;
      S_ARG:  state_d = S_PRD;
      S_PRD:  state_d = S_PWT;
      S_PWT: begin
        if (ready) begin
          res_d   = dec_res;
          state_d = S_ARR;
        end else if (tmr_last) begin
          res_d   = RES_TIMEOUT;
          state_d = S_ARR;
        end else begin
          state_d = S_PRD;
        end
      end
      S_ARR: begin
        if (erase_q || (res_q == RES_OK)) begin
          state_d = S_VRD;
        end else begin
          state_d = S_DONE;
        end
      end
      S_VRD:  state_d = S_VWT;
      S_VWT: begin
        if (!match) begin
          if (res_q == RES_OK) begin
            res_d = RES_VERIFY;
          end
          state_d = S_DONE;
        end else if (erase_q && !sw_last) begin
          state_d = S_VRD;
        end else begin
          state_d = S_DONE;
        end
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      res_q   <= RES_OK;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
    end
  end

  // request capture, enabled only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      limit_q <= '0;
    end else if (start_acc) begin
      erase_q <= req_erase;
      addr_q  <= req_addr;
      data_q  <= req_data;
      limit_q <= poll_limit;
    end
  end

  // flash bus decode
  always_comb begin
    fl_we    = 1'b0;
    fl_re    = 1'b0;
    fl_addr  = addr_q;
    fl_wdata = '0;
    unique case (state_q)
      S_CLR: begin
        fl_we    = 1'b1;
        fl_wdata = DW'(CMD_CLR_STAT);
      end
      S_CMD: begin
        fl_we    = 1'b1;
        fl_wdata = erase_q ? DW'(CMD_ERASE) : DW'(CMD_PROGRAM);
      end
      S_ARG: begin
        fl_we    = 1'b1;
        fl_wdata = erase_q ? DW'(CMD_CONFIRM) : data_q;
      end
      S_PRD: fl_re = 1'b1;
      S_ARR: begin
        fl_we    = 1'b1;
        fl_wdata = DW'(CMD_ARRAY);
      end
      S_VRD: begin
        fl_re   = 1'b1;
        fl_addr = erase_q ? sw_addr : addr_q;
      end
      default: ;
    endcase
  end

  assign busy   = (state_q != S_IDLE);
  assign done   = (state_q == S_DONE);
  assign result = res_q;

endmodule

// File: rtl/nflash_seq_chk.sv
module nflash_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_start,
  input logic [AW-1:0] req_addr,
  input logic          busy,
  input logic          done,
  input logic [2:0]    result,
  input logic          fl_we,
  input logic          fl_re,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_wdata
);

  p_bus_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_start) |=> (busy && fl_we && (fl_wdata[7:0] == 8'h50)
                              && (fl_addr == $past(req_addr))));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_start) |=> $stable(result));

  p_busy_until_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

endmodule

bind nflash_seq nflash_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_start (req_start),
  .req_addr  (req_addr),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .fl_we     (fl_we),
  .fl_re     (fl_re),
  .fl_addr   (fl_addr),
  .fl_wdata  (fl_wdata)
);

// File: tb/nflash_seq_tb.sv
module nflash_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TW = 16;
  localparam int BLK = 16;

  typedef struct packed {
    logic        er;
    logic [7:0]  addr;
    logic [15:0] data;
    logic [15:0] lim;
    logic [7:0]  lat;
    logic [7:0]  inj;
    logic        stk;
    logic        cor;
    logic [2:0]  exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{1'b1, 8'h25, 16'h0000, 16'd10, 8'd2,  8'h00, 1'b0, 1'b0, 3'd0},
    '{1'b0, 8'h31, 16'h1234, 16'd10, 8'd1,  8'h00, 1'b0, 1'b0, 3'd0},
    '{1'b1, 8'h47, 16'h0000, 16'd5,  8'd20, 8'h00, 1'b0, 1'b0, 3'd1},
    '{1'b0, 8'h52, 16'h00F0, 16'd10, 8'd0,  8'h08, 1'b0, 1'b0, 3'd2},
    '{1'b1, 8'h63, 16'h0000, 16'd10, 8'd1,  8'h2A, 1'b0, 1'b0, 3'd3},
    '{1'b0, 8'h70, 16'h5555, 16'd10, 8'd1,  8'h12, 1'b0, 1'b0, 3'd4},
    '{1'b1, 8'h8A, 16'h0000, 16'd10, 8'd3,  8'h20, 1'b0, 1'b0, 3'd5},
    '{1'b0, 8'h91, 16'hA5A5, 16'd10, 8'd0,  8'h10, 1'b0, 1'b0, 3'd6},
    '{1'b1, 8'hA4, 16'h0000, 16'd10, 8'd1,  8'h00, 1'b1, 1'b0, 3'd7},
    '{1'b1, 8'hB0, 16'h0000, 16'd10, 8'd1,  8'h22, 1'b1, 1'b0, 3'd4},
    '{1'b0, 8'hC5, 16'h0F0F, 16'd10, 8'd2,  8'h00, 1'b0, 1'b1, 3'd7},
    '{1'b0, 8'hD2, 16'h7777, 16'd3,  8'd9,  8'h00, 1'b0, 1'b0, 3'd1},
    '{1'b0, 8'hE3, 16'h3C3C, 16'd5,  8'd4,  8'h00, 1'b0, 1'b0, 3'd0},
    '{1'b1, 8'hF0, 16'h0000, 16'd5,  8'd5,  8'h00, 1'b0, 1'b0, 3'd1},
    '{1'b0, 8'h0C, 16'h4242, 16'd0,  8'd0,  8'h00, 1'b0, 1'b0, 3'd0},
    '{1'b1, 8'h15, 16'h0000, 16'd10, 8'd0,  8'h10, 1'b0, 1'b0, 3'd2}
  };

  logic          clk;
  logic          rst_n;
  logic          req_start;
  logic          req_erase;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic [TW-1:0] poll_limit;
  logic          busy;
  logic          done;
  logic [2:0]    result;
  logic          fl_we;
  logic          fl_re;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata;

  int n_chk;
  int n_bad;

  nflash_seq #(.AW(AW), .DW(DW), .BLK_LOG2(4), .TW(TW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .req_erase  (req_erase),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .poll_limit (poll_limit),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .fl_we      (fl_we),
    .fl_re      (fl_re),
    .fl_addr    (fl_addr),
    .fl_wdata   (fl_wdata),
    .fl_rdata   (fl_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural flash model
  logic [15:0] mem [256];
  logic [7:0]  m_lat;
  logic [7:0]  m_inj;
  logic        m_stk;
  logic [7:0]  m_stk_addr;
  logic        m_cor;
  int          st_reads;
  int          arr_reads;
  int          wcount;
  logic [15:0] wlog_d [8];
  logic [7:0]  wlog_a [8];
  logic        m_status;
  logic [1:0]  m_pend;
  int          m_rem;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);
      m_status  = 1'b0;
      m_pend    = 2'd0;
      m_rem     = 0;
      st_reads  = 0;
      arr_reads = 0;
      wcount    = 0;
      fl_rdata <= '0;
    end else begin
      if (fl_we) begin
        wlog_d[wcount % 8] = fl_wdata;
        wlog_a[wcount % 8] = fl_addr;
        wcount++;
        if (m_pend == 2'd2) begin
          mem[fl_addr] = m_cor ? (fl_wdata ^ 16'h0001) : fl_wdata;
          m_pend   = 2'd0;
          m_status = 1'b1;
          m_rem    = int'(m_lat);
        end else if (m_pend == 2'd1) begin
          m_pend = 2'd0;
          if (fl_wdata == 16'h00D0) begin
            for (int i = 0; i < BLK; i++) mem[{fl_addr[7:4], 4'(i)}] = 16'hFFFF;
            m_status = 1'b1;
            m_rem    = int'(m_lat);
          end
        end else begin
          case (fl_wdata)
            16'h0020: m_pend = 2'd1;
            16'h0040: m_pend = 2'd2;
            16'h0070: m_status = 1'b1;
            16'h00FF: m_status = 1'b0;
            default: ;
          endcase
        end
      end
      if (fl_re) begin
        if (m_status) begin
          st_reads++;
          if (m_rem > 0) begin
            m_rem--;
            fl_rdata <= 16'h0000;
          end else begin
            fl_rdata <= {8'h00, 8'h80 | m_inj};
          end
        end else begin
          arr_reads++;
          if (m_stk && (fl_addr == m_stk_addr)) fl_rdata <= mem[fl_addr] & 16'hFFFE;
          else fl_rdata <= mem[fl_addr];
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic er, input logic [7:0] a, input logic [15:0] d,
                        input logic [15:0] lim, output int dones);
    int guard;
    dones = 0;
    guard = 0;
    @(negedge clk);
    req_start  = 1'b1;
    req_erase  = er;
    req_addr   = a;
    req_data   = d;
    poll_limit = lim;
    @(negedge clk);
    req_start = 1'b0;
    while (busy && guard < 1000) begin
      if (done) dones++;
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic int min_i(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int dn;
    int s0, a0, w0;
    int exp_st, exp_arr, lim_eff;
    logic [2:0] held;
    n_chk = 0;
    n_bad = 0;
    req_start = 1'b0; req_erase = 1'b0; req_addr = '0; req_data = '0; poll_limit = '0;
    m_lat = '0; m_inj = '0; m_stk = 1'b0; m_stk_addr = '0; m_cor = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // reset state: R8, R9
    chk(!busy && !done, "R9 reset busy/done", {busy, done}, 0);
    chk(result == 3'd0, "R8 reset result", result, 0);
    chk(!fl_we && !fl_re, "R11 reset strobes", {fl_we, fl_re}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R2 R3 R4 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      m_lat = VT[v].lat; m_inj = VT[v].inj; m_cor = VT[v].cor;
      m_stk = VT[v].stk; m_stk_addr = {VT[v].addr[7:4], 4'd3};
      s0 = st_reads; a0 = arr_reads; w0 = wcount;
      run_op(VT[v].er, VT[v].addr, VT[v].data, VT[v].lim, dn);
      lim_eff = (VT[v].lim == 0) ? 1 : int'(VT[v].lim);
      exp_st = min_i(int'(VT[v].lat) + 1, lim_eff);
      if (VT[v].er) exp_arr = VT[v].stk ? 4 : BLK;
      else exp_arr = (VT[v].exp == 3'd0 || VT[v].exp == 3'd7) ? 1 : 0;
      chk(result == VT[v].exp, $sformatf("R4 vec %0d result", v), result, VT[v].exp);
      chk(st_reads - s0 == exp_st, $sformatf("R3 vec %0d status reads", v), st_reads - s0, exp_st);
      chk(arr_reads - a0 == exp_arr, $sformatf("R6 R7 vec %0d array reads", v), arr_reads - a0, exp_arr);
      chk(wcount - w0 == 4, $sformatf("R2 vec %0d write count", v), wcount - w0, 4);
      chk(dn == 1, $sformatf("R9 vec %0d done pulses", v), dn, 1);
      if (!VT[v].er && VT[v].exp == 3'd0)
        chk(mem[VT[v].addr] == VT[v].data, $sformatf("R7 vec %0d stored", v), mem[VT[v].addr], VT[v].data);
    end

    // program bus sequence: R1 R2 R5
    m_lat = 8'd1; m_inj = 8'h00; m_stk = 1'b0; m_cor = 1'b0;
    w0 = wcount;
    run_op(1'b0, 8'h44, 16'h9A9A, 16'd8, dn);
    chk(wlog_d[w0 % 8] == 16'h0050 && wlog_a[w0 % 8] == 8'h44, "R1 clear status first", wlog_d[w0 % 8], 16'h50);
    chk(wlog_d[(w0+1) % 8] == 16'h0040, "R2 program command", wlog_d[(w0+1) % 8], 16'h40);
    chk(wlog_d[(w0+2) % 8] == 16'h9A9A && wlog_a[(w0+2) % 8] == 8'h44, "R2 program data", wlog_d[(w0+2) % 8], 16'h9A9A);
    chk(wlog_d[(w0+3) % 8] == 16'h00FF, "R5 read-array restore", wlog_d[(w0+3) % 8], 16'hFF);

    // erase bus sequence: R2 R5
    w0 = wcount;
    run_op(1'b1, 8'h57, 16'h0000, 16'd8, dn);
    chk(wlog_d[(w0+1) % 8] == 16'h0020 && wlog_d[(w0+2) % 8] == 16'h00D0 && wlog_a[(w0+2) % 8] == 8'h57,
        "R2 erase command pair", wlog_d[(w0+2) % 8], 16'hD0);
    chk(wlog_d[(w0+3) % 8] == 16'h00FF, "R5 erase restore", wlog_d[(w0+3) % 8], 16'hFF);

    // start while busy ignored: R10
    m_lat = 8'd3;
    s0 = st_reads; a0 = arr_reads; w0 = wcount;
    dn = 0;
    @(negedge clk);
    req_start = 1'b1; req_erase = 1'b0; req_addr = 8'h40; req_data = 16'hBEEF; poll_limit = 16'd8;
    @(negedge clk);
    req_start = 1'b0;
    @(negedge clk);
    req_start = 1'b1; req_erase = 1'b1; req_addr = 8'h0E; req_data = 16'h0000;
    @(negedge clk);
    req_start = 1'b0;
    for (int g = 0; g < 200 && busy; g++) begin
      if (done) dn++;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk(!busy, "R10 idle after op", busy, 0);
    chk(dn == 1, "R10 single done", dn, 1);
    chk(wcount - w0 == 4, "R10 write count", wcount - w0, 4);
    chk(mem[8'h40] == 16'hBEEF, "R10 programmed word", mem[8'h40], 16'hBEEF);
    chk(mem[8'h0E] == 16'h100E, "R10 other block untouched", mem[8'h0E], 16'h100E);

    // result held until next start: R8
    m_lat = 8'd0; m_cor = 1'b1;
    run_op(1'b0, 8'h66, 16'h2222, 16'd4, dn);
    held = result;
    repeat (12) @(negedge clk);
    chk(held == 3'd7 && result == held, "R8 result held", result, 7);
    m_cor = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule